// File: doc/BRIEF.md
# Serial Receive Queue with Per-Character Status

This block receives asynchronous serial characters on a single line and deserializes them. It samples the line at sixteen times the bit rate, using a tick from a built-in clock divider. Each frame has a start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. Each finished character goes into a shallow queue. The character's parity verdict and an overrun marker are stored with it, so the status a reader sees always belongs to the character it is about to take.

A host polls the read side. It looks at the head character and three flags: character available, parity error and overrun. It pulses a read strobe to drop the head entry and move to the next one. Control inputs turn the receiver on and select the parity checking mode. Turning the receiver off stops it at once and discards everything that has not been read.

Top module: `serial_rx_queue`

## Requirements
- R1: A frame made of a low start bit, eight data bits sent least significant bit first and a high stop bit is delivered on `rd_data`. `rd_avail` stays high while at least one unread character is queued.
- R2: When `par_chk` is 1, a parity bit follows the eighth data bit. For even mode (`par_odd`=0) the expected parity bit is the XOR of the data bits; for odd mode (`par_odd`=1) it is the inverse of that XOR. `rd_perr` is 1 for a character whose received parity bit differs from the expected one.
- R3: A character received while `par_chk` was 0 has no parity bit on the line and always shows `rd_perr`=0.
- R4: The flags and data describe the head entry only. A one-cycle `rd_stb` removes the head, and the next character and its own flags appear on the following cycle.
- R5: The queue holds two characters. A frame that completes while both slots are full is discarded. The next character that is stored carries `rd_ovr`=1, and the flag is gone once that character has been read.
- R6: A read strobe while `rd_avail` is 0 leaves the queue unchanged.
- R7: A start bit is accepted only if the line is still low at the middle of the bit. A low pulse shorter than half a bit produces no character.
- R8: Dropping `rx_on` aborts any frame in progress and empties the queue. `rd_avail` is 0 on the next cycle.
- R9: After reset `rd_avail`, `rd_perr` and `rd_ovr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_on | input | 1 | Receiver enable; low aborts the frame in progress and flushes the queue |
| par_chk | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rxd | input | 1 | Asynchronous serial input, idle high |
| rd_stb | input | 1 | One-cycle pulse that pops the head character |
| rd_data | output | 8 | Head character |
| rd_avail | output | 1 | At least one unread character is queued |
| rd_perr | output | 1 | Head character failed its parity check |
| rd_ovr | output | 1 | A character was lost just before the head character |

## Verification
The bench builds the block with a clock divider of 2, so one bit lasts 32 clock cycles and a full frame with idle gap takes a few hundred cycles. At that length, dozens of random frames fit in the run, mixing parity modes, corrupted parity bits and random read patterns. The queue depth stays at its default of 2, so three back-to-back frames are enough to overflow it. This makes the overrun marker, and the way it clears, reachable through plain directed sequences.

// File: rtl/srq_pkg.sv
package srq_pkg;
  localparam int unsigned CHAR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_t;

  typedef struct packed {
    logic              perr;
    logic [CHAR_W-1:0] data;
  } rx_char_t;

  typedef struct packed {
    logic              ovr;
    logic              perr;
    logic [CHAR_W-1:0] data;
  } q_entry_t;
endpackage

// File: rtl/srq_baud.sv
module srq_baud #(
  parameter int unsigned DIV = 27
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/srq_deser.sv
module srq_deser
  import srq_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     run,
  input  logic     tick,
  input  logic     rxd_s,
  input  logic     par_chk,
  input  logic     par_odd,
  output logic     frm_vld,
  output rx_char_t frm
);
  localparam int unsigned CW  = $clog2(OVS);
  localparam int unsigned NBW = $clog2(CHAR_W);
  localparam logic [CW-1:0]  MID   = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0]  LAST  = CW'(OVS - 1);
  localparam logic [NBW-1:0] LASTB = NBW'(CHAR_W - 1);

  rx_state_t         st;
  logic [CW-1:0]     cnt;
  logic [NBW-1:0]    nbit;
  logic [CHAR_W-1:0] shreg;
  logic              pbit;
  logic              f_chk;
  logic              f_odd;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      nbit    <= '0;
      frm_vld <= 1'b0;
      f_chk   <= 1'b0;
      f_odd   <= 1'b0;
    end else begin
      frm_vld <= 1'b0;
      if (tick) begin
        case (st)
          ST_IDLE: if (!rxd_s) begin
            st    <= ST_START;
            cnt   <= '0;
            f_chk <= par_chk;
            f_odd <= par_odd;
          end
          ST_START: if (cnt == MID) begin
            cnt  <= '0;
            nbit <= '0;
            st   <= rxd_s ? ST_IDLE : ST_DATA;
          end else cnt <= cnt + 1'b1;
          ST_DATA: if (cnt == LAST) begin
            cnt   <= '0;
            shreg <= {rxd_s, shreg[CHAR_W-1:1]};
            if (nbit == LASTB) st <= f_chk ? ST_PAR : ST_STOP;
            else               nbit <= nbit + 1'b1;
          end else cnt <= cnt + 1'b1;
          ST_PAR: if (cnt == LAST) begin
            cnt  <= '0;
            pbit <= rxd_s;
            st   <= ST_STOP;
          end else cnt <= cnt + 1'b1;
          ST_STOP: if (cnt == LAST) begin
            cnt      <= '0;
            st       <= ST_IDLE;
            frm_vld  <= 1'b1;
            frm.data <= shreg;
            frm.perr <= f_chk && (pbit != ((^shreg) ^ f_odd));
          end else cnt <= cnt + 1'b1;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/srq_fifo.sv
module srq_fifo
  import srq_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     flush,
  input  logic     push,
  input  rx_char_t push_char,
  input  logic     pop,
  output q_entry_t head,
  output logic     avail,
  output logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned FW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] PLAST = PW'(DEPTH - 1);
  localparam logic [FW-1:0] FULLV = FW'(DEPTH);

  q_entry_t      mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          ovr_pend;
  logic          full, do_pop, do_push;

  assign full    = (fill == FULLV);
  assign avail   = (fill != '0);
  assign do_pop  = pop && avail;
  assign do_push = push && (!full || do_pop);

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= '{ovr: ovr_pend, perr: push_char.perr, data: push_char.data};
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr     <= '0;
      rptr     <= '0;
      fill     <= '0;
      ovr_pend <= 1'b0;
    end else begin
      if (do_push) wptr <= (wptr == PLAST) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == PLAST) ? '0 : rptr + 1'b1;
      if (do_push && !do_pop)      fill <= fill + 1'b1;
      else if (do_pop && !do_push) fill <= fill - 1'b1;
      if (do_push)              ovr_pend <= 1'b0;
      else if (push)            ovr_pend <= 1'b1;
    end
  end

  assign head = avail ? mem[rptr] : '0;
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import srq_pkg::*;
#(
  parameter int unsigned TICK_DIV = 27,
  parameter int unsigned OVS      = 16,
  parameter int unsigned DEPTH    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_on,
  input  logic              par_chk,
  input  logic              par_odd,
  input  logic              rxd,
  input  logic              rd_stb,
  output logic [CHAR_W-1:0] rd_data,
  output logic              rd_avail,
  output logic              rd_perr,
  output logic              rd_ovr
);
  localparam int unsigned FW = $clog2(DEPTH + 1);

  logic [1:0]    sync;
  logic          tick;
  logic          frm_vld;
  rx_char_t      frm;
  q_entry_t      head;
  logic [FW-1:0] fill;

  always_ff @(posedge clk) begin
    if (rst) sync <= 2'b11;
    else     sync <= {sync[0], rxd};
  end

  srq_baud #(.DIV(TICK_DIV)) baud_i (
    .clk(clk), .rst(rst), .run(rx_on), .tick(tick)
  );

  srq_deser #(.OVS(OVS)) deser_i (
    .clk(clk), .rst(rst), .run(rx_on), .tick(tick), .rxd_s(sync[1]),
    .par_chk(par_chk), .par_odd(par_odd), .frm_vld(frm_vld), .frm(frm)
  );

  srq_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .flush(!rx_on), .push(frm_vld), .push_char(frm),
    .pop(rd_stb), .head(head), .avail(rd_avail), .fill(fill)
  );

  assign rd_data = head.data;
  assign rd_perr = head.perr;
  assign rd_ovr  = head.ovr;
endmodule

// File: rtl/srq_checker.sv
module srq_checker #(
  parameter int unsigned DEPTH = 2
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       rx_on,
  input logic                       rd_stb,
  input logic [7:0]                 rd_data,
  input logic                       rd_avail,
  input logic                       rd_perr,
  input logic                       rd_ovr,
  input logic                       frm_vld,
  input logic [$clog2(DEPTH+1)-1:0] fill
);
  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> (!rd_avail && !rd_perr && !rd_ovr));

  a_r8_disable_flush: assert property (@(posedge clk) disable iff (rst)
    !rx_on |=> !rd_avail);

  a_r4_flags_need_data: assert property (@(posedge clk) disable iff (rst)
    !rd_avail |-> (!rd_perr && !rd_ovr));

  a_r4_pop_last: assert property (@(posedge clk) disable iff (rst)
    (rx_on && rd_stb && fill == 1 && !frm_vld) |=> !rd_avail);

  a_r6_empty_read: assert property (@(posedge clk) disable iff (rst)
    (rx_on && rd_stb && !rd_avail && !frm_vld) |=> !rd_avail);

  a_r5_full_drop: assert property (@(posedge clk) disable iff (rst)
    (rx_on && frm_vld && !rd_stb && fill == ($clog2(DEPTH+1))'(DEPTH)) |=>
      (rd_avail && $stable(rd_data)));
endmodule

bind serial_rx_queue srq_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .rx_on(rx_on), .rd_stb(rd_stb), .rd_data(rd_data),
  .rd_avail(rd_avail), .rd_perr(rd_perr), .rd_ovr(rd_ovr),
  .frm_vld(frm_vld), .fill(fill)
);

// File: tb/serial_rx_queue_tb_top.sv
`timescale 1ns/1ps
module serial_rx_queue_tb_top;
  localparam int DIV = 2;
  localparam int BIT = 16 * DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_on = 1'b0, par_chk = 1'b0, par_odd = 1'b0, rxd = 1'b1, rd_stb = 1'b0;
  logic [7:0] rd_data;
  logic rd_avail, rd_perr, rd_ovr;

  int checks = 0, failures = 0;
  logic [9:0] q[$];
  logic pend = 1'b0;

  always #2 clk = ~clk;

  serial_rx_queue #(.TICK_DIV(DIV), .OVS(16), .DEPTH(2)) dut_i (
    .clk(clk), .rst(rst), .rx_on(rx_on), .par_chk(par_chk), .par_odd(par_odd),
    .rxd(rxd), .rd_stb(rd_stb), .rd_data(rd_data), .rd_avail(rd_avail),
    .rd_perr(rd_perr), .rd_ovr(rd_ovr)
  );

  function automatic logic good_par(logic [7:0] d, logic odd);
    return (^d) ^ odd;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [7:0] d, logic flip);
    logic pb;
    pb = good_par(d, par_odd) ^ flip;
    rxd = 1'b0; hold(BIT);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; hold(BIT); end
    if (par_chk) begin rxd = pb; hold(BIT); end
    rxd = 1'b1; hold(BIT);
    hold(BIT);
    if (q.size() < 2) begin
      q.push_back({pend, par_chk & flip, d});
      pend = 1'b0;
    end else pend = 1'b1;
  endtask

  task automatic look(string req);
    chk({req, " avail"}, rd_avail, q.size() > 0);
    if (q.size() > 0) begin
      chk({req, " data"}, rd_data, q[0][7:0]);
      chk({req, " perr"}, rd_perr, q[0][8]);
      chk({req, " ovr"},  rd_ovr,  q[0][9]);
    end
  endtask

  task automatic pop(string req);
    look(req);
    rd_stb = 1'b1; hold(1); rd_stb = 1'b0;
    if (q.size() > 0) void'(q.pop_front());
    hold(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    hold(4);
    rst = 1'b0;
    hold(1);
    // R9 reset state
    chk("R9 avail", rd_avail, 0);
    chk("R9 perr", rd_perr, 0);
    chk("R9 ovr", rd_ovr, 0);
    rx_on = 1'b1; hold(BIT);

    // R1 plain frames
    send(8'hA5, 0); look("R1");
    send(8'h01, 0); pop("R1"); pop("R1"); look("R1 empty");
    // R6 read on empty
    pop("R6"); chk("R6 avail", rd_avail, 0);
    send(8'h3C, 0); pop("R6 after");

    // R2 parity even/odd, good and bad
    par_chk = 1'b1; par_odd = 1'b0;
    send(8'h7E, 0); send(8'h7F, 1); pop("R2 even ok"); pop("R2 even bad");
    par_odd = 1'b1;
    send(8'h80, 1); send(8'h00, 0); pop("R2 odd bad"); pop("R2 odd ok");
    // R3 checking off
    par_chk = 1'b0;
    send(8'hFF, 1); pop("R3");

    // R5 overrun
    send(8'h11, 0); send(8'h22, 0); send(8'h33, 0);
    look("R5 head"); pop("R5 first");
    send(8'h44, 0); pop("R5 second"); look("R5 marked"); pop("R5 marked");
    look("R5 cleared");
    send(8'h55, 0); pop("R5 cleared next");

    // R7 glitch rejection
    rxd = 1'b0; hold(BIT / 4); rxd = 1'b1; hold(3 * BIT);
    chk("R7 glitch", rd_avail, 0);

    // R8 disable flush and abort
    send(8'h66, 0); send(8'h77, 0);
    rxd = 1'b0; hold(BIT); rxd = 1'b1; hold(3 * BIT);
    rx_on = 1'b0; hold(1);
    chk("R8 flush", rd_avail, 0);
    q.delete(); pend = 1'b0;
    rxd = 1'b1; hold(8 * BIT); rx_on = 1'b1; hold(2 * BIT);
    chk("R8 aborted", rd_avail, 0);
    send(8'h99, 0); pop("R8 resume");

    // random mix
    for (int n = 0; n < 40; n++) begin
      logic [31:0] r;
      r = $urandom(1234 + n);
      par_chk = r[8]; par_odd = r[9];
      send(r[7:0], r[10]);
      for (int k = 0; k < int'(r[12:11]) % 3; k++) pop("R4 random");
      look("R4 random");
    end
    while (q.size() > 0) pop("R4 drain");
    look("R1 drained");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule